// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This unit takes two IEEE 754 binary32 operands and a 3-bit operation code. It computes one of five results: equality, strict less-than, less-or-equal, minimum or maximum. The three compares return a single integer bit. Minimum and maximum return a 32-bit floating-point value.

Alongside the result the unit raises an invalid-operation bit. The surrounding pipeline ORs this bit into an accrued exception-flag register that lives elsewhere, and software clears that register. The unit never traps.

The rules for NaN operands depend on the operation. Less-than and less-or-equal treat every NaN as invalid. Equality only objects to signaling NaNs. Minimum and maximum prefer the number over the NaN, and they order negative zero below positive zero. The result is held in an output register stage, so it appears one clock after the operands. A parameter can remove this stage.

Top module: `fcmp_unit`

## Requirements
- R1: For LT (code 1) and LE (code 2), flag_nv is 1 whenever either operand is any NaN, and cmp_bit is 0 in that case.
- R2: For EQ (code 0), flag_nv is 1 only when an operand is a signaling NaN. A signaling NaN has an all-ones exponent (bits 30:23), a nonzero mantissa and bit 22 clear. A quiet NaN has bit 22 set and raises no flag.
- R3: Every compare (EQ, LT, LE) returns cmp_bit 0 when either operand is a NaN, quiet or signaling.
- R4: Compares of non-NaN operands follow numeric order, including infinities, subnormals and negative values. Positive zero and negative zero compare equal: EQ gives 1, LT gives 0 and LE gives 1.
- R5: For MIN (code 3) and MAX (code 4), negative zero is strictly below positive zero. MIN of the two zeros gives 0x80000000 and MAX gives 0x00000000, whichever operand order is used.
- R6: MIN or MAX with both operands NaN returns the canonical NaN 0x7FC00000.
- R7: MIN or MAX with exactly one NaN operand returns the other operand bit for bit. Otherwise it returns the smaller operand (MIN) or the larger operand (MAX).
- R8: MIN and MAX raise flag_nv when either operand is a signaling NaN, even when the result is a number. Quiet NaNs raise no flag.
- R9: Operation codes 5, 6 and 7 give cmp_bit 0, fp_res 0 and flag_nv 0.
- R10: Outputs are registered. They reflect the inputs present at the previous rising clock edge, and all outputs are 0 while rst_n is low. fp_res is 0 for the compares, and cmp_bit is 0 for MIN and MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_sel | input | 3 | Operation code: 0 EQ, 1 LT, 2 LE, 3 MIN, 4 MAX |
| src_a | input | 32 | First binary32 operand |
| src_b | input | 32 | Second binary32 operand |
| cmp_bit | output | 1 | Integer result of a compare |
| fp_res | output | 32 | Floating-point result of MIN or MAX |
| flag_nv | output | 1 | Invalid-operation flag for this operation |

## Verification
The assertions assume that the operands and the operation code are stable and known at each rising edge. A check made in a cycle after reset refers to inputs sampled one edge earlier. The bench changes inputs only on falling edges and reads outputs on the next falling edge.

Random operands are drawn so that they often hit special encodings: both zeros, both infinities, quiet and signaling NaNs of either sign, subnormals, the largest finite value, and equal operand pairs. This keeps the NaN and zero rules exercised far more often than uniform random bits would.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam logic [2:0] OP_EQ  = 3'd0;
    localparam logic [2:0] OP_LT  = 3'd1;
    localparam logic [2:0] OP_LE  = 3'd2;
    localparam logic [2:0] OP_MIN = 3'd3;
    localparam logic [2:0] OP_MAX = 3'd4;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
    } fcls_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output fcmp_pkg::fcls_t      cls
);
    localparam int FP_W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f       = val[FP_W-2:MAN_W];
        man_f       = val[MAN_W-1:0];
        cls.is_nan  = (&exp_f) && (|man_f);
        cls.is_snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
        cls.is_zero = ~|val[FP_W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  logic                 zero_a,
    input  logic                 zero_b,
    output logic                 lt_num,
    output logic                 eq_num,
    output logic                 lt_tot
);
    localparam int FP_W = EXP_W + MAN_W + 1;

    logic mag_lt, mag_eq, both_zero;

    always_comb begin
        mag_lt    = a[FP_W-2:0] < b[FP_W-2:0];
        mag_eq    = a[FP_W-2:0] == b[FP_W-2:0];
        both_zero = zero_a && zero_b;
        eq_num    = (a == b) || both_zero;
        if (a[FP_W-1] != b[FP_W-1]) begin
            lt_num = a[FP_W-1] && !both_zero;
            lt_tot = a[FP_W-1];
        end else if (!a[FP_W-1]) begin
            lt_num = mag_lt;
            lt_tot = mag_lt;
        end else begin
            lt_num = !mag_lt && !mag_eq;
            lt_tot = !mag_lt && !mag_eq;
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op_sel,
    input  logic [EXP_W+MAN_W:0]   src_a,
    input  logic [EXP_W+MAN_W:0]   src_b,
    output logic                   cmp_bit,
    output logic [EXP_W+MAN_W:0]   fp_res,
    output logic                   flag_nv
);
    import fcmp_pkg::*;

    localparam int FP_W = EXP_W + MAN_W + 1;
    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic            cmp;
        logic [FP_W-1:0] res;
        logic            nv;
    } fout_t;

    logic [FP_W-1:0] opnd [2];
    fcls_t           cls  [2];
    logic            lt_num, eq_num, lt_tot;
    logic            any_nan, both_nan, any_snan;
    fout_t           out_d, out_q;

    always_comb begin
        opnd[0] = src_a;
        opnd[1] = src_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (opnd[i]),
            .cls (cls[i])
        );
    end

    fcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
        .a      (src_a),
        .b      (src_b),
        .zero_a (cls[0].is_zero),
        .zero_b (cls[1].is_zero),
        .lt_num (lt_num),
        .eq_num (eq_num),
        .lt_tot (lt_tot)
    );

    always_comb begin
        any_nan  = cls[0].is_nan || cls[1].is_nan;
        both_nan = cls[0].is_nan && cls[1].is_nan;
        any_snan = cls[0].is_snan || cls[1].is_snan;
        out_d    = '0;
        case (op_sel)
            OP_EQ: begin
                out_d.cmp = !any_nan && eq_num;
                out_d.nv  = any_snan;
            end
            OP_LT: begin
                out_d.cmp = !any_nan && lt_num;
                out_d.nv  = any_nan;
            end
            OP_LE: begin
                out_d.cmp = !any_nan && (lt_num || eq_num);
                out_d.nv  = any_nan;
            end
            OP_MIN, OP_MAX: begin
                out_d.nv = any_snan;
                if (both_nan)             out_d.res = CANON_NAN;
                else if (cls[0].is_nan)   out_d.res = src_b;
                else if (cls[1].is_nan)   out_d.res = src_a;
                else if (op_sel == OP_MIN) out_d.res = lt_tot ? src_a : src_b;
                else                       out_d.res = lt_tot ? src_b : src_a;
            end
            default: out_d = '0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        assert_ltle_nan_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_sel) == OP_LT || $past(op_sel) == OP_LE) && $past(any_nan))
            |-> (flag_nv && !cmp_bit));

        assert_eq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_sel) == OP_EQ && !$past(any_snan)) |-> !flag_nv);

        assert_cmp_nan_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_sel) <= OP_LE && $past(any_nan)) |-> !cmp_bit);

        assert_two_nan_canon_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_sel) == OP_MIN || $past(op_sel) == OP_MAX) && $past(both_nan))
            |-> (fp_res == CANON_NAN));

        assert_one_nan_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_sel) == OP_MIN || $past(op_sel) == OP_MAX)
             && $past(cls[0].is_nan) && !$past(cls[1].is_nan)) |-> (fp_res == $past(src_b)));

        assert_pick_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_sel) == OP_MIN || $past(op_sel) == OP_MAX) && !$past(any_nan))
            |-> (fp_res == $past(src_a) || fp_res == $past(src_b)));

        assert_minmax_snan_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_sel) == OP_MIN || $past(op_sel) == OP_MAX) && $past(any_snan))
            |-> flag_nv);

        assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_sel) > OP_MAX) |-> (!cmp_bit && !flag_nv && fp_res == '0));
    end else begin : g_comb
        always_comb out_q = out_d;
    end

    always_comb begin
        cmp_bit = out_q.cmp;
        fp_res  = out_q.res;
        flag_nv = out_q.nv;
    end
endmodule

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        cmp_bit;
    logic [31:0] fp_res;
    logic        flag_nv;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fcmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .cmp_bit(cmp_bit), .fp_res(fp_res), .flag_nv(flag_nv)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction
    function automatic logic signed [33:0] key(input logic [31:0] x);
        logic signed [33:0] m;
        m = $signed({3'b000, x[30:0]});
        return x[31] ? -m : m;
    endfunction

    // returns {cmp, nv, res}
    function automatic logic [33:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        logic signed [33:0] ka, kb;
        bit na, nb, sn;
        logic [31:0] r;
        ka = key(a); kb = key(b);
        na = is_nan(a); nb = is_nan(b); sn = is_snan(a) || is_snan(b);
        case (op)
            3'd0: return {!na && !nb && ka == kb, sn, 32'h0};
            3'd1: return {!na && !nb && ka < kb, na || nb, 32'h0};
            3'd2: return {!na && !nb && ka <= kb, na || nb, 32'h0};
            3'd3, 3'd4: begin
                if (na && nb) r = 32'h7FC00000;
                else if (na) r = b;
                else if (nb) r = a;
                else if (ka == kb) r = (op == 3'd3) ? (a[31] ? a : b) : (a[31] ? b : a);
                else if (op == 3'd3) r = (ka < kb) ? a : b;
                else r = (ka > kb) ? a : b;
                return {1'b0, sn, r};
            end
            default: return 34'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b);
        logic [33:0] exp_v;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b;
        exp_v = model(op, a, b);
        @(negedge clk);
        n_run++;
        if ({cmp_bit, flag_nv, fp_res} !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual cmp=%b nv=%b res=%h expected cmp=%b nv=%b res=%h",
                     tag, op, a, b, cmp_bit, flag_nv, fp_res, exp_v[33], exp_v[32], exp_v[31:0]);
        end
    endtask

    function automatic logic [31:0] special(input int k);
        case (k)
            0: return 32'h00000000;  1: return 32'h80000000;
            2: return 32'h7F800000;  3: return 32'hFF800000;
            4: return 32'h7FC00000;  5: return 32'hFFC00001;
            6: return 32'h7F800001;  7: return 32'hFFA00000;
            8: return 32'h3F800000;  9: return 32'hBF800000;
            10: return 32'h00000001; 11: return 32'h80000001;
            default: return 32'h7F7FFFFF;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        if (op <= 3'd2) return "R4";
        if (op <= 3'd4) return "R7";
        return "R9";
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd20181220);
        src_a = 32'h7F800001; src_b = 32'h3F800000; op_sel = 3'd1;
        repeat (3) @(negedge clk);
        n_run++;
        if ({cmp_bit, flag_nv, fp_res} !== 34'h0) begin
            n_fail++;
            $display("FAIL R10 reset actual %b%b%h expected 0", cmp_bit, flag_nv, fp_res);
        end
        rst_n = 1'b1;
        check("R1", 3'd1, 32'h7FC00000, 32'h3F800000);
        check("R1", 3'd2, 32'h3F800000, 32'hFFC00000);
        check("R2", 3'd0, 32'h7FC00000, 32'h7FC00000);
        check("R2", 3'd0, 32'h7F800001, 32'h3F800000);
        check("R3", 3'd0, 32'h7FC00000, 32'h3F800000);
        check("R4", 3'd0, 32'h80000000, 32'h00000000);
        check("R4", 3'd1, 32'h80000000, 32'h00000000);
        check("R4", 3'd2, 32'h00000000, 32'h80000000);
        check("R4", 3'd1, 32'hBF800000, 32'hC0000000);
        check("R5", 3'd3, 32'h00000000, 32'h80000000);
        check("R5", 3'd3, 32'h80000000, 32'h00000000);
        check("R5", 3'd4, 32'h80000000, 32'h00000000);
        check("R5", 3'd4, 32'h00000000, 32'h80000000);
        check("R6", 3'd3, 32'h7F800001, 32'hFFC00000);
        check("R7", 3'd4, 32'h7FC00000, 32'hBF800000);
        check("R7", 3'd3, 32'h3F800000, 32'hFFC00000);
        check("R8", 3'd3, 32'h7FA00000, 32'h40000000);
        check("R8", 3'd4, 32'h40000000, 32'h7FC00000);
        check("R9", 3'd5, 32'h7F800001, 32'h3F800000);
        check("R9", 3'd7, 32'h3F800000, 32'h40000000);
        check("R10", 3'd3, 32'h3F800000, 32'h40000000);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [2:0]  op;
            a  = ($urandom % 3 == 0) ? $urandom : special($urandom % 13);
            b  = ($urandom % 3 == 0) ? $urandom : special($urandom % 13);
            if ($urandom % 8 == 0) b = a;
            op = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
            check(tag_of(op), op, a, b);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule